// File: doc/BRIEF.md
# PCI Status Register Error and Abort Bits

This block keeps the five error and abort flags that sit in the upper half of a PCI configuration status register. The bus interface feeds it single-cycle event pulses: a target abort this device issued, a target abort received while mastering, a master abort, an address-phase parity error and a data-phase parity error. Two enables taken from the command register shape the response. The SERR enable gates the system-error flag and the active-low system-error output. The parity-error-response enable has no effect on the detected-parity flag. Each flag is sticky. Configuration software clears a flag by writing a 1 to its bit position. Every flag is also copied to a local-side status vector.

Two small state machines carry the timing. The abort-request machine has states ABT_IDLE and ABT_PEND. It moves ABT_IDLE to ABT_PEND when the local side raises its abort request without a target-abort event in the same cycle. It moves ABT_PEND to ABT_IDLE when the target-abort event arrives. It stays in ABT_IDLE when the request and the event coincide. A target-abort event without a request, current or pending, sets nothing. The system-error machine has states SERR_IDLE and SERR_DRIVE. It moves SERR_IDLE to SERR_DRIVE on an address parity error while SERR is enabled. It stays in SERR_DRIVE while such errors keep arriving every cycle. It moves SERR_DRIVE to SERR_IDLE otherwise. The output is low only in SERR_DRIVE.

A configuration port selects either the status halfword or an 8-bit revision register. The revision value is a parameter and cannot be written.

Top module: `pci_err_status`

## Requirements
- R1: Status bit 11 (signaled target abort) sets on a cycle with `tgt_abort_evt` high when `loc_abort_req` is high in that cycle or was raised earlier and not yet consumed. That event consumes the pending request. A `tgt_abort_evt` with no request sets nothing.
- R2: Status bit 12 (received target abort) sets on `rx_tabort_evt` only while `mst_active` is 1.
- R3: Status bit 13 (master abort) sets on `mst_abort_evt` only while `mst_active` is 1.
- R4: An `addr_perr_evt` with `serr_en` = 1 sets status bit 14. It also drives `serr_n` low for exactly the clock after that edge. With `serr_en` = 0, neither happens.
- R5: Status bit 15 (detected parity error) sets on `addr_perr_evt` or `data_perr_evt`, whatever the value of `perr_resp_en`.
- R6: `loc_stat[5:1]` equals status bits 15..11 (bit 11 on `loc_stat[1]`), and `loc_stat[0]` is 0.
- R7: With `cfg_sel` = 0, `cfg_rdata[15:11]` returns the status bits and `cfg_rdata[10:0]` reads 0.
- R8: With `cfg_sel` = 1, `cfg_rdata` returns {8'h00, REV_ID}. Writes with `cfg_sel` = 1 change neither this value nor any status bit.
- R9: A write with `cfg_sel` = 0 clears each status bit whose `cfg_wdata` bit (15..11) is 1. A 0 leaves the bit unchanged.
- R10: When a set event and a write-1-to-clear hit the same bit in the same clock, the bit ends up set.
- R11: After reset, all status bits are 0, `serr_n` is 1 and no abort request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_active | input | 1 | Device is currently acting as bus master |
| loc_abort_req | input | 1 | Local side asks for a target abort |
| tgt_abort_evt | input | 1 | Pulse: this device ended a transaction with target abort |
| rx_tabort_evt | input | 1 | Pulse: addressed target returned a target abort |
| mst_abort_evt | input | 1 | Pulse: this device ended its transaction with master abort |
| addr_perr_evt | input | 1 | Pulse: address-phase parity error detected |
| data_perr_evt | input | 1 | Pulse: data-phase parity error detected |
| serr_en | input | 1 | SERR enable from the command register |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| cfg_sel | input | 1 | 0 selects the status halfword, 1 the revision register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for the selected register |
| serr_n | output | 1 | Active-low system-error output |
| loc_stat | output | 6 | Local-side copy of the status flags |

## Verification
Internal state here is the five flags and the two machine states. A corrupted flag shows on `loc_stat` and on status reads in the very next cycle. A lost pending abort request appears only when the next target-abort event fails to set bit 11, so the stimulus spaces requests and events apart by random gaps. A stuck system-error state shows as `serr_n` held low one cycle past its single pulse. The bench therefore compares every output against its own model on every cycle.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

    // Number of sticky flags and where they sit inside the status halfword
    localparam int NUM_ERR  = 5;
    localparam int STAT_LSB = 11;
    localparam int CFG_DW   = 16;
    localparam int REV_W    = 8;

    // Flag positions inside the internal vector (bit STAT_LSB + index)
    localparam int IDX_STA = 0;   // signaled target abort
    localparam int IDX_RTA = 1;   // received target abort
    localparam int IDX_MA  = 2;   // master abort
    localparam int IDX_SSE = 3;   // signaled system error
    localparam int IDX_DPE = 4;   // detected parity error

    typedef enum logic {
        ABT_IDLE = 1'b0,
        ABT_PEND = 1'b1
    } abt_state_t;

    typedef enum logic {
        SERR_IDLE  = 1'b0,
        SERR_DRIVE = 1'b1
    } serr_state_t;

endpackage

// File: rtl/pci_err_sticky.sv
module pci_err_sticky #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    // One flop per flag; set has priority over clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                q[i] <= 1'b0;
            end
        end

        // R10: simultaneous set and clear leaves the flag at 1
        a_r10_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && clr_vec[i]) |=> q[i]);

        // R9: a clear without a set drops the flag
        a_r9_clear : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !q[i]);

        // R9: a flag only rises on a set request
        a_r9_sticky_rise : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[i]) |-> $past(set_vec[i]));
    end

endmodule

// File: rtl/pci_err_abort_fsm.sv
module pci_err_abort_fsm
    import pci_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loc_abort_req,
    input  logic tgt_abort_evt,
    output logic set_sta
);

    abt_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ABT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ABT_IDLE: begin
                if (loc_abort_req && !tgt_abort_evt) begin
                    state_d = ABT_PEND;
                end
            end
            ABT_PEND: begin
                if (tgt_abort_evt) begin
                    state_d = ABT_IDLE;
                end
            end
            default: state_d = ABT_IDLE;
        endcase
    end

    always_comb begin
        set_sta = 1'b0;
        unique case (state_q)
            ABT_IDLE: set_sta = tgt_abort_evt && loc_abort_req;
            ABT_PEND: set_sta = tgt_abort_evt;
            default:  set_sta = 1'b0;
        endcase
    end

    // R1: a target abort with no request, current or pending, sets nothing
    a_r1_needs_request : assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_abort_evt && !loc_abort_req && state_q == ABT_IDLE) |-> !set_sta);

    // R1: a pending request is consumed by the event
    a_r1_consume : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ABT_PEND && tgt_abort_evt) |=> (state_q == ABT_IDLE));

endmodule

// File: rtl/pci_err_serr_fsm.sv
module pci_err_serr_fsm
    import pci_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_perr_evt,
    input  logic serr_en,
    output logic set_sse,
    output logic serr_n
);

    serr_state_t state_q, state_d;
    logic        qualify;

    assign qualify = addr_perr_evt && serr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SERR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SERR_IDLE:  state_d = qualify ? SERR_DRIVE : SERR_IDLE;
            SERR_DRIVE: state_d = qualify ? SERR_DRIVE : SERR_IDLE;
            default:    state_d = SERR_IDLE;
        endcase
    end

    always_comb begin
        set_sse = qualify;
        serr_n  = 1'b1;
        unique case (state_q)
            SERR_IDLE:  serr_n = 1'b1;
            SERR_DRIVE: serr_n = 1'b0;
            default:    serr_n = 1'b1;
        endcase
    end

    // R4: qualifying address parity error pulls SERR low in the next cycle
    a_r4_serr_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        (addr_perr_evt && serr_en) |=> !serr_n);

    // R4: SERR is never low without a qualifying error one cycle earlier
    a_r4_serr_cause : assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(addr_perr_evt && serr_en));

endmodule

// File: rtl/pci_err_cfg_port.sv
module pci_err_cfg_port
    import pci_err_pkg::*;
#(
    parameter logic [REV_W-1:0] REV_ID = 8'h01
) (
    input  logic               cfg_sel,
    input  logic               cfg_wr,
    input  logic [CFG_DW-1:0]  cfg_wdata,
    input  logic [NUM_ERR-1:0] stat_q,
    output logic [NUM_ERR-1:0] clr_vec,
    output logic [CFG_DW-1:0]  cfg_rdata
);

    localparam int PAD_W = CFG_DW - REV_W;

    logic unused_low_wdata;
    assign unused_low_wdata = ^cfg_wdata[STAT_LSB-1:0];

    // Clear strobes only when the status halfword is selected
    assign clr_vec = (cfg_wr && !cfg_sel) ? cfg_wdata[CFG_DW-1:STAT_LSB] : '0;

    always_comb begin
        if (cfg_sel) begin
            cfg_rdata = {{PAD_W{1'b0}}, REV_ID};
        end else begin
            cfg_rdata = {stat_q, {STAT_LSB{1'b0}}};
        end
    end

    // R8: revision writes never produce clear strobes
    a_r8_rev_no_clear : assert property (@(posedge cfg_wr)
        cfg_sel |-> (clr_vec == '0));

endmodule

// File: rtl/pci_err_status.sv
module pci_err_status
    import pci_err_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mst_active,
    input  logic        loc_abort_req,
    input  logic        tgt_abort_evt,
    input  logic        rx_tabort_evt,
    input  logic        mst_abort_evt,
    input  logic        addr_perr_evt,
    input  logic        data_perr_evt,
    input  logic        serr_en,
    input  logic        perr_resp_en,
    input  logic        cfg_sel,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    output logic        serr_n,
    output logic [5:0]  loc_stat
);

    logic [NUM_ERR-1:0] set_vec;
    logic [NUM_ERR-1:0] clr_vec;
    logic [NUM_ERR-1:0] stat_q;
    logic               set_sta;
    logic               set_sse;
    logic               unused_perr_resp;

    // Parity response enable does not gate the detected-parity flag
    assign unused_perr_resp = perr_resp_en;

    pci_err_abort_fsm u_abort (
        .clk           (clk),
        .rst_n         (rst_n),
        .loc_abort_req (loc_abort_req),
        .tgt_abort_evt (tgt_abort_evt),
        .set_sta       (set_sta)
    );

    pci_err_serr_fsm u_serr (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_perr_evt (addr_perr_evt),
        .serr_en       (serr_en),
        .set_sse       (set_sse),
        .serr_n        (serr_n)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[IDX_STA] = set_sta;
        set_vec[IDX_RTA] = rx_tabort_evt && mst_active;
        set_vec[IDX_MA]  = mst_abort_evt && mst_active;
        set_vec[IDX_SSE] = set_sse;
        set_vec[IDX_DPE] = addr_perr_evt || data_perr_evt;
    end

    pci_err_sticky #(.W(NUM_ERR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (stat_q)
    );

    pci_err_cfg_port #(.REV_ID(REV_ID)) u_cfg (
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .stat_q    (stat_q),
        .clr_vec   (clr_vec),
        .cfg_rdata (cfg_rdata)
    );

    assign loc_stat = {stat_q, 1'b0};

    // R5: any parity error sets the detected flag, even with response disabled
    a_r5_dpe_ungated : assert property (@(posedge clk) disable iff (!rst_n)
        (data_perr_evt && !perr_resp_en) |=> loc_stat[5]);

    // R2: received target abort outside master mode leaves bit 12 alone
    a_r2_slave_ignore : assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_active && !loc_stat[2] && !(cfg_wr && !cfg_sel && cfg_wdata[12]))
            |=> !loc_stat[2]);

    // R3: master abort in master mode sets bit 13
    a_r3_master_abort : assert property (@(posedge clk) disable iff (!rst_n)
        (mst_abort_evt && mst_active) |=> loc_stat[3]);

    // R6: local vector bit 0 carries no flag
    a_r6_lsb_zero : assert property (@(posedge clk) disable iff (!rst_n)
        !loc_stat[0]);

endmodule

// File: tb/pci_err_status_tb.sv
module pci_err_status_tb;

    localparam logic [7:0] REV = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mst_active = 0, loc_abort_req = 0, tgt_abort_evt = 0;
    logic        rx_tabort_evt = 0, mst_abort_evt = 0, addr_perr_evt = 0;
    logic        data_perr_evt = 0, serr_en = 0, perr_resp_en = 0;
    logic        cfg_sel = 0, cfg_wr = 0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        serr_n;
    logic [5:0]  loc_stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [4:0] m_stat = '0;
    logic       m_pend = 0;
    logic       m_serr_n = 1;

    always #5 clk = ~clk;

    pci_err_status #(.REV_ID(REV)) u_dut (
        .clk(clk), .rst_n(rst_n), .mst_active(mst_active),
        .loc_abort_req(loc_abort_req), .tgt_abort_evt(tgt_abort_evt),
        .rx_tabort_evt(rx_tabort_evt), .mst_abort_evt(mst_abort_evt),
        .addr_perr_evt(addr_perr_evt), .data_perr_evt(data_perr_evt),
        .serr_en(serr_en), .perr_resp_en(perr_resp_en), .cfg_sel(cfg_sel),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .serr_n(serr_n), .loc_stat(loc_stat)
    );

    function automatic logic [15:0] exp_rdata(input logic sel, input logic [4:0] st);
        return sel ? {8'h00, REV} : {st, 11'b0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all();
        chk("R1", "bit11", {15'b0, loc_stat[1]}, {15'b0, m_stat[0]});
        chk("R2", "bit12", {15'b0, loc_stat[2]}, {15'b0, m_stat[1]});
        chk("R3", "bit13", {15'b0, loc_stat[3]}, {15'b0, m_stat[2]});
        chk("R4", "bit14", {15'b0, loc_stat[4]}, {15'b0, m_stat[3]});
        chk("R5", "bit15", {15'b0, loc_stat[5]}, {15'b0, m_stat[4]});
        chk("R4", "serr_n", {15'b0, serr_n}, {15'b0, m_serr_n});
        chk("R6", "loc_stat", {10'b0, loc_stat}, {10'b0, m_stat, 1'b0});
        chk(cfg_sel ? "R8" : "R7", "cfg_rdata", cfg_rdata, exp_rdata(cfg_sel, m_stat));
    endtask

    // Model advance, evaluated from the inputs held across the edge
    task automatic model_step();
        logic [4:0] set, clr;
        logic sta;
        sta = tgt_abort_evt && (m_pend || loc_abort_req);
        if (sta) m_pend = 0;
        else if (loc_abort_req) m_pend = 1;
        set = {addr_perr_evt || data_perr_evt, addr_perr_evt && serr_en,
               mst_abort_evt && mst_active, rx_tabort_evt && mst_active, sta};
        clr = (cfg_wr && !cfg_sel) ? cfg_wdata[15:11] : 5'b0;
        m_stat = (m_stat & ~clr) | set;
        m_serr_n = !(addr_perr_evt && serr_en);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        loc_abort_req = 0; tgt_abort_evt = 0; rx_tabort_evt = 0;
        mst_abort_evt = 0; addr_perr_evt = 0; data_perr_evt = 0;
        cfg_wr = 0; cfg_wdata = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the run completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1BAD5EED);
        repeat (3) @(negedge clk);
        // R11: reset state
        check_all();
        rst_n = 1;
        @(negedge clk);
        check_all();

        // R1: target abort without request sets nothing
        tgt_abort_evt = 1; cycle(); idle_inputs();
        chk("R1", "no request", {15'b0, loc_stat[1]}, 16'h0);
        loc_abort_req = 1; cycle(); idle_inputs();
        cycle(); cycle();
        tgt_abort_evt = 1; cycle(); idle_inputs();
        chk("R1", "pending request consumed", {15'b0, loc_stat[1]}, 16'h1);
        tgt_abort_evt = 1; cycle(); idle_inputs();   // no second request pending
        cfg_wr = 1; cfg_wdata = 16'h0800; cycle(); idle_inputs();
        chk("R9", "bit11 cleared", {15'b0, loc_stat[1]}, 16'h0);

        // R2, R3: master-mode gating
        mst_active = 0; rx_tabort_evt = 1; mst_abort_evt = 1; cycle(); idle_inputs();
        chk("R2", "slave ignores", {14'b0, loc_stat[3:2]}, 16'h0);
        mst_active = 1; rx_tabort_evt = 1; mst_abort_evt = 1; cycle(); idle_inputs();
        chk("R3", "master sets", {14'b0, loc_stat[3:2]}, 16'h3);

        // R4, R5: parity with SERR disabled then enabled
        serr_en = 0; perr_resp_en = 0; addr_perr_evt = 1; cycle(); idle_inputs();
        chk("R4", "serr disabled", {15'b0, serr_n}, 16'h1);
        serr_en = 1; addr_perr_evt = 1; cycle(); idle_inputs();
        chk("R4", "serr low", {15'b0, serr_n}, 16'h0);
        cycle();
        chk("R4", "serr single clock", {15'b0, serr_n}, 16'h1);
        cfg_wr = 1; cfg_wdata = 16'h8000; cycle(); idle_inputs();
        data_perr_evt = 1; cycle(); idle_inputs();
        chk("R5", "dpe with response off", {15'b0, loc_stat[5]}, 16'h1);

        // R9: write of zero, R8: revision write ignored
        cfg_wr = 1; cfg_wdata = 16'h0000; cycle(); idle_inputs();
        cfg_sel = 1; cfg_wr = 1; cfg_wdata = 16'hFFFF; cycle(); idle_inputs();
        chk("R8", "rev after write", cfg_rdata, {8'h00, REV});
        cfg_sel = 0; @(negedge clk) ; check_all();

        // R10: set and clear collide
        rx_tabort_evt = 1; cfg_wr = 1; cfg_wdata = 16'hF800; cycle(); idle_inputs();
        chk("R10", "set wins", {11'b0, loc_stat[5:1]}, 16'h0002);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            mst_active    = ($urandom % 4) != 0;
            loc_abort_req = ($urandom % 6) == 0;
            tgt_abort_evt = ($urandom % 5) == 0;
            rx_tabort_evt = ($urandom % 6) == 0;
            mst_abort_evt = ($urandom % 6) == 0;
            addr_perr_evt = ($urandom % 7) == 0;
            data_perr_evt = ($urandom % 7) == 0;
            serr_en       = ($urandom % 2) == 0;
            perr_resp_en  = ($urandom % 2) == 0;
            cfg_sel       = ($urandom % 3) == 0;
            cfg_wr        = ($urandom % 4) == 0;
            cfg_wdata     = 16'($urandom);
            cycle();
        end
        idle_inputs();
        cycle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule